// File: doc/BRIEF.md
# DDR Bring-Up Sequencer

This block steps a DDR PHY and its memory controller from power-up to a usable state in a fixed order. On a start pulse it drives the DRAM reset pin low and holds it for a timed window. It then lifts the controller's forced reset, turns on the SSTL pad bank and launches pad impedance calibration with fixed drive-strength and termination codes. The calibration enable stays high until the calibration circuit clears it. After that the sequencer checks the calibration error flag.

When calibration succeeds, the clock, command and termination output drivers are switched on and a one-cycle strobe tells the controller to latch its configuration and timing registers. The DRAM reset is then released and held high for a second timed window, and a boot-attempt counter steps. A one-cycle pulse starts controller initialisation. The sequencer waits for the init-done flag and then for a settle window before it reports done. A calibration error, or a timeout on either wait, sends it to a failure state. That state steps a failure counter and stops driving the DRAM reset pin. A new start pulse from done or from failure runs the whole sequence again.

All windows are counted in ticks of a prescaled timebase, one tick every `TICK_DIV` clocks. The hold, settle and timeout lengths are parameters.

Top module: `ddr_bringup_seq`

## Requirements
- R1: After synchronous reset the sequencer is idle: `dram_rst_n`=0, `dram_rst_oe`=0, `ctl_force_rst`=1, every enable, strobe and flag low, both counters 0.
- R2: A `start` pulse seen in idle, done or failure moves to the reset-hold state. That state drives `dram_rst_n`=0 with `dram_rst_oe`=1 for exactly HOLD_TICKS*TICK_DIV+1 cycles. `start` has no effect in every other state.
- R3: The cycle after the hold ends, `ctl_force_rst` drops. One cycle later `sstl_ena` rises, and one cycle after that `cal_en` rises. `drive_code` and `odt_code` always equal their parameters (default 7).
- R4: `cal_en` stays high until the cycle after a `cal_clear` pulse. The following cycle is a check cycle. If `cal_err` is 1 there, the sequencer enters failure, otherwise it continues.
- R5: If `cal_en` is still high after TIMEOUT_TICKS*TICK_DIV+1 cycles of calibration, the sequencer enters failure.
- R6: `ck_oe`, `cmd_oe` and `odt_oe` rise in the cycle after a clean check. `cfg_load` pulses for one cycle in the cycle after that, with the output enables already high.
- R7: After the load strobe, `dram_rst_n` goes high and the sequencer holds it there for HOLD_TICKS*TICK_DIV+1 cycles. `boot_cnt` steps by one as that window begins.
- R8: `init_go` then pulses for exactly one cycle, and the sequencer waits for `init_done`. If no `init_done` arrives within TIMEOUT_TICKS*TICK_DIV+1 cycles, it enters failure.
- R9: After `init_done`, a settle window of SETTLE_TICKS*TICK_DIV+1 cycles follows, then done: `seq_done`=1 and all drivers stay on, with `dram_rst_n`=1.
- R10: Entering failure steps `fail_cnt` by one and sets `seq_fail`=1. In failure `dram_rst_oe`=0, `ctl_force_rst`=1, `dram_rst_n`=0, and every pad and driver enable is 0.
- R11: `boot_cnt` and `fail_cnt` keep their values across restarts, wrap modulo 2^CNT_W, and clear only on reset.
- R12: `seq_state` codes: 0 idle, 1 reset-hold, 2 controller release, 3 pad enable, 4 calibrating, 5 calibration check, 6 driver enable, 7 register load, 8 reset release, 9 init trigger, 10 init wait, 11 settle, 12 done, 13 failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start or restart pulse |
| cal_clear | input | 1 | Calibration circuit clears the enable |
| cal_err | input | 1 | Calibration error flag |
| init_done | input | 1 | Controller initialisation finished |
| dram_rst_n | output | 1 | DRAM reset pin level (low = reset) |
| dram_rst_oe | output | 1 | DRAM reset pin output enable |
| ctl_force_rst | output | 1 | Forced reset of the memory controller |
| sstl_ena | output | 1 | SSTL pad bank enable |
| cal_en | output | 1 | Calibration enable, cleared by `cal_clear` |
| drive_code | output | 3 | Pad drive-strength code |
| odt_code | output | 3 | Pad termination code |
| ck_oe | output | 1 | Clock output driver enable |
| cmd_oe | output | 1 | Command output driver enable |
| odt_oe | output | 1 | Termination output driver enable |
| cfg_load | output | 1 | One-cycle register-load strobe |
| init_go | output | 1 | One-cycle initialisation trigger |
| seq_done | output | 1 | Sequence complete |
| seq_fail | output | 1 | Sequence failed |
| seq_state | output | 4 | Current step code (R12) |
| boot_cnt | output | CNT_W | Boot attempts |
| fail_cnt | output | CNT_W | Failures |

## Verification
Every output is a registered-state decode. A `start`, `cal_clear` or `init_done` sampled at one edge therefore shows on the outputs straight after that edge. The exceptions are `cal_en`, which falls one edge after `cal_clear`, and the check step, which follows one edge later. Timed windows last N*TICK_DIV+1 cycles from the state change, because the tick counter restarts on entry and the exit decision is registered. The bench drives inputs and compares a behavioural model against every output on the falling edge. At that point the design has settled after the rising edge that the model also stepped on.

// File: rtl/ddr_bu_pkg.sv
// Package: shared step encoding for the DDR bring-up sequencer.
// Assumes: the order of codes is significant; output decode uses ranges.
package ddr_bu_pkg;
    typedef enum logic [3:0] {
        ST_IDLE   = 4'd0,
        ST_HOLD   = 4'd1,
        ST_CREL   = 4'd2,
        ST_PADS   = 4'd3,
        ST_CAL    = 4'd4,
        ST_CCHK   = 4'd5,
        ST_DRV    = 4'd6,
        ST_LOAD   = 4'd7,
        ST_RREL   = 4'd8,
        ST_ITRIG  = 4'd9,
        ST_IWAIT  = 4'd10,
        ST_SETTLE = 4'd11,
        ST_DONE   = 4'd12,
        ST_FAIL   = 4'd13
    } seq_st_e;
endpackage

// File: rtl/bu_tick_timer.sv
// Module: prescaled tick timer. Emits one tick every DIV clocks and counts
// the ticks since the last clear, saturating at all-ones.
// Assumes: clr is asserted on the edge that enters a new step, so the count
// restarts at zero in the first cycle of that step.
module bu_tick_timer #(
    parameter int DIV = 25,
    parameter int TW  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [TW-1:0] tcnt
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] PLAST = PW'(DIV - 1);

    logic [PW-1:0] presc_q;

    // Prescaler and tick counter, both restarted by clr.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            presc_q <= '0;
            tcnt    <= '0;
        end else if (presc_q == PLAST) begin
            presc_q <= '0;
            if (tcnt != '1) tcnt <= tcnt + 1'b1;
        end else begin
            presc_q <= presc_q + 1'b1;
        end
    end

    // R2: the count only ever holds or steps by one between clears.
    a_r2_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (tcnt == $past(tcnt) || tcnt == $past(tcnt) + 1'b1));
endmodule

// File: rtl/bu_event_ctr.sv
// Module: wrapping event counter, cleared only by reset.
// Assumes: inc is a one-cycle pulse per event.
module bu_event_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    // Count events modulo 2^W.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

    // R11: the counter moves only on an event.
    a_r11_hold_no_inc: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> cnt == $past(cnt));
endmodule

// File: rtl/ddr_bringup_seq.sv
// Module: DDR bring-up sequencer top. Walks the reset, pad, calibration,
// register-load and initialisation steps in a fixed order with timed holds
// and timeouts, and ends in done or failure.
// Assumes: all outputs are decoded from registered state; inputs are
// synchronous to clk.
module ddr_bringup_seq
    import ddr_bu_pkg::*;
#(
    parameter int TICK_DIV      = 25,
    parameter int HOLD_TICKS    = 10000,
    parameter int SETTLE_TICKS  = 10000,
    parameter int TIMEOUT_TICKS = 50000,
    parameter int DRV_CODE      = 7,
    parameter int ODT_CODE      = 7,
    parameter int CNT_W         = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cal_clear,
    input  logic             cal_err,
    input  logic             init_done,
    output logic             dram_rst_n,
    output logic             dram_rst_oe,
    output logic             ctl_force_rst,
    output logic             sstl_ena,
    output logic             cal_en,
    output logic [2:0]       drive_code,
    output logic [2:0]       odt_code,
    output logic             ck_oe,
    output logic             cmd_oe,
    output logic             odt_oe,
    output logic             cfg_load,
    output logic             init_go,
    output logic             seq_done,
    output logic             seq_fail,
    output logic [3:0]       seq_state,
    output logic [CNT_W-1:0] boot_cnt,
    output logic [CNT_W-1:0] fail_cnt
);
    localparam int MAXT0 = (HOLD_TICKS > SETTLE_TICKS) ? HOLD_TICKS : SETTLE_TICKS;
    localparam int MAXT  = (MAXT0 > TIMEOUT_TICKS) ? MAXT0 : TIMEOUT_TICKS;
    localparam int TW    = $clog2(MAXT + 1) + 1;
    localparam logic [TW-1:0] T_HOLD   = TW'(HOLD_TICKS);
    localparam logic [TW-1:0] T_SETTLE = TW'(SETTLE_TICKS);
    localparam logic [TW-1:0] T_TMO    = TW'(TIMEOUT_TICKS);

    seq_st_e       st_q, st_nxt;
    logic [TW-1:0] tcnt;
    logic          cal_q;
    logic          tmr_clr;

    assign tmr_clr = (st_nxt != st_q);

    bu_tick_timer #(.DIV(TICK_DIV), .TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tcnt(tcnt)
    );

    // Next-step selection.
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE, ST_DONE, ST_FAIL: if (start) st_nxt = ST_HOLD;
            ST_HOLD:   if (tcnt >= T_HOLD) st_nxt = ST_CREL;
            ST_CREL:   st_nxt = ST_PADS;
            ST_PADS:   st_nxt = ST_CAL;
            ST_CAL: begin
                if (!cal_q)              st_nxt = ST_CCHK;
                else if (tcnt >= T_TMO)  st_nxt = ST_FAIL;
            end
            ST_CCHK:   st_nxt = cal_err ? ST_FAIL : ST_DRV;
            ST_DRV:    st_nxt = ST_LOAD;
            ST_LOAD:   st_nxt = ST_RREL;
            ST_RREL:   if (tcnt >= T_HOLD) st_nxt = ST_ITRIG;
            ST_ITRIG:  st_nxt = ST_IWAIT;
            ST_IWAIT: begin
                if (init_done)           st_nxt = ST_SETTLE;
                else if (tcnt >= T_TMO)  st_nxt = ST_FAIL;
            end
            ST_SETTLE: if (tcnt >= T_SETTLE) st_nxt = ST_DONE;
            default:   st_nxt = ST_IDLE;
        endcase
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nxt;
    end

    // Calibration enable: set on entry, cleared by the calibration circuit or on leaving.
    always_ff @(posedge clk) begin
        if (!rst_n)                              cal_q <= 1'b0;
        else if (st_q == ST_PADS)                cal_q <= 1'b1;
        else if (cal_clear || st_nxt != ST_CAL)  cal_q <= 1'b0;
    end

    bu_event_ctr #(.W(CNT_W)) u_boot_ctr (
        .clk(clk), .rst_n(rst_n), .inc(st_q == ST_LOAD), .cnt(boot_cnt)
    );

    bu_event_ctr #(.W(CNT_W)) u_fail_ctr (
        .clk(clk), .rst_n(rst_n),
        .inc(st_nxt == ST_FAIL && st_q != ST_FAIL), .cnt(fail_cnt)
    );

    // Output decode from the registered step.
    always_comb begin
        dram_rst_oe   = !(st_q == ST_IDLE || st_q == ST_FAIL);
        dram_rst_n    = (st_q >= ST_RREL) && (st_q <= ST_DONE);
        ctl_force_rst = (st_q == ST_IDLE) || (st_q == ST_HOLD) || (st_q == ST_FAIL);
        sstl_ena      = (st_q >= ST_PADS) && (st_q <= ST_DONE);
        ck_oe         = (st_q >= ST_DRV) && (st_q <= ST_DONE);
        cmd_oe        = ck_oe;
        odt_oe        = ck_oe;
        cfg_load      = (st_q == ST_LOAD);
        init_go       = (st_q == ST_ITRIG);
        seq_done      = (st_q == ST_DONE);
        seq_fail      = (st_q == ST_FAIL);
        seq_state     = st_q;
        cal_en        = cal_q;
        drive_code    = 3'(DRV_CODE);
        odt_code      = 3'(ODT_CODE);
    end

    // R3: the pads are never on while the controller is held in reset.
    a_r3_pads_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        sstl_ena |-> !ctl_force_rst);
    // R4: a clear pulse drops the calibration enable at the next edge.
    a_r4_cal_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_en && cal_clear) |=> !cal_en);
    // R6: the load strobe comes with the drivers already on a cycle earlier.
    a_r6_drivers_before_load: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |-> (ck_oe && cmd_oe && odt_oe && $past(ck_oe)));
    // R7: each release of the DRAM reset steps the boot counter.
    a_r7_boot_step: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_rst_n) |-> boot_cnt == CNT_W'($past(boot_cnt) + 1'b1));
    // R8: the init trigger is a single-cycle pulse.
    a_r8_init_single: assert property (@(posedge clk) disable iff (!rst_n)
        init_go |=> !init_go);
    // R10: entering failure steps the failure counter.
    a_r10_fail_step: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_fail) |-> fail_cnt == CNT_W'($past(fail_cnt) + 1'b1));
endmodule

// File: tb/ddr_bringup_seq_test.sv
`timescale 1ns/1ps
module ddr_bringup_seq_test;
    localparam int DIV = 2, HOLD = 3, SETL = 2, TMO = 5, CW = 2;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic cal_clear = 1'b0, cal_err = 1'b0, init_done = 1'b0;
    logic dram_rst_n, dram_rst_oe, ctl_force_rst, sstl_ena, cal_en;
    logic [2:0] drive_code, odt_code;
    logic ck_oe, cmd_oe, odt_oe, cfg_load, init_go, seq_done, seq_fail;
    logic [3:0] seq_state;
    logic [CW-1:0] boot_cnt, fail_cnt;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    int cal_lat = 0, init_lat = 0, err_val = 0;
    int cal_wait = 0, init_wait = 0;

    // behavioural model state
    int m_st = 0, m_k = 1, m_cal = 0, m_boot = 0, m_fail = 0;

    always #2 clk = ~clk;

    ddr_bringup_seq #(.TICK_DIV(DIV), .HOLD_TICKS(HOLD), .SETTLE_TICKS(SETL),
        .TIMEOUT_TICKS(TMO), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cal_clear(cal_clear),
        .cal_err(cal_err), .init_done(init_done), .dram_rst_n(dram_rst_n),
        .dram_rst_oe(dram_rst_oe), .ctl_force_rst(ctl_force_rst),
        .sstl_ena(sstl_ena), .cal_en(cal_en), .drive_code(drive_code),
        .odt_code(odt_code), .ck_oe(ck_oe), .cmd_oe(cmd_oe), .odt_oe(odt_oe),
        .cfg_load(cfg_load), .init_go(init_go), .seq_done(seq_done),
        .seq_fail(seq_fail), .seq_state(seq_state), .boot_cnt(boot_cnt),
        .fail_cnt(fail_cnt));

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
        end
    endtask

    // Reference model, stepped on each rising edge with the sampled inputs.
    always @(posedge clk) begin
        int o, n, t;
        if (!rst_n) begin
            m_st = 0; m_k = 1; m_cal = 0; m_boot = 0; m_fail = 0;
        end else begin
            o = m_st; n = o; t = (m_k - 1) / DIV;
            case (o)
                0, 12, 13: if (start) n = 1;
                1:  if (t >= HOLD) n = 2;
                2:  n = 3;
                3:  n = 4;
                4:  if (m_cal == 0) n = 5; else if (t >= TMO) n = 13;
                5:  n = cal_err ? 13 : 6;
                6:  n = 7;
                7:  begin n = 8; m_boot = (m_boot + 1) % (1 << CW); end
                8:  if (t >= HOLD) n = 9;
                9:  n = 10;
                10: if (init_done) n = 11; else if (t >= TMO) n = 13;
                11: if (t >= SETL) n = 12;
                default: n = 0;
            endcase
            if (o == 3) m_cal = 1;
            else if (cal_clear || n != 4) m_cal = 0;
            if (n == 13 && o != 13) m_fail = (m_fail + 1) % (1 << CW);
            m_k = (n != o) ? 1 : m_k + 1;
            m_st = n;
        end
    end

    // Per-clock comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R12 state", seq_state, m_st);
            chk("R2/R10 rst_oe", dram_rst_oe, !(m_st == 0 || m_st == 13));
            chk("R7 dram_rst_n", dram_rst_n, (m_st >= 8 && m_st <= 12));
            chk("R3 force_rst", ctl_force_rst, (m_st <= 1 || m_st == 13));
            chk("R3 sstl", sstl_ena, (m_st >= 3 && m_st <= 12));
            chk("R4 cal_en", cal_en, m_cal);
            chk("R6 drivers", {ck_oe, cmd_oe, odt_oe},
                (m_st >= 6 && m_st <= 12) ? 7 : 0);
            chk("R6 cfg_load", cfg_load, m_st == 7);
            chk("R8 init_go", init_go, m_st == 9);
            chk("R9 done", seq_done, m_st == 12);
            chk("R10 fail", seq_fail, m_st == 13);
            chk("R7 boot_cnt", boot_cnt, m_boot);
            chk("R10 fail_cnt", fail_cnt, m_fail);
            chk("R3 codes", {drive_code, odt_code}, 6'o77);
        end
    end

    // Environment: calibration circuit and controller responses.
    always @(negedge clk) begin
        if (cal_en) cal_wait++; else cal_wait = 0;
        cal_clear = (cal_en && cal_lat >= 0 && cal_wait == cal_lat + 1);
        cal_err = (err_val != 0);
        if (seq_state == 4'd10) init_wait++; else init_wait = 0;
        init_done = (init_lat >= 0 && init_wait == init_lat + 1);
    end

    task automatic run(input int cl, input int er, input int il);
        cal_lat = cl; err_val = er; init_lat = il;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (seq_done || seq_fail) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 state", seq_state, 0);
        chk("R1 dram_rst_n", dram_rst_n, 0);
        chk("R1 force_rst", ctl_force_rst, 1);
        chk("R1 counters", {boot_cnt, fail_cnt}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // good run
        run(2, 0, 3);
        chk("R9 done reached", seq_done, 1);
        chk("R7 boot one", boot_cnt, 1);
        // start ignored mid-sequence (R2), then calibration error (R4)
        cal_lat = 3; err_val = 1; init_lat = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (9) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        chk("R2 start ignored", seq_state, 4);
        for (int i = 0; i < 100 && !seq_fail; i++) @(negedge clk);
        chk("R4 cal error fail", seq_fail, 1);
        chk("R10 fail one", fail_cnt, 1);
        chk("R10 rst_oe off", dram_rst_oe, 0);
        // R5: calibration never clears
        run(-1, 0, 0);
        chk("R5 cal timeout", {seq_fail, 2'(fail_cnt)}, 4 + 2);
        // R8: init never done
        run(0, 0, -1);
        chk("R8 init timeout", {seq_fail, 2'(fail_cnt)}, 4 + 3);
        chk("R8 boot two", boot_cnt, 2);
        // good runs, boot counter wraps (R11)
        run(0, 0, 0);
        chk("R9 done again", seq_done, 1);
        run(1, 0, 2);
        chk("R11 boot wrap", boot_cnt, 0);
        run(0, 1, 0);
        chk("R11 fail wrap", fail_cnt, 0);
        repeat (3) @(negedge clk);
        chk("R10 fail held", seq_fail, 1);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end
endmodule